// File: doc/BRIEF.md
# Lane-wise Rounding Shift-Right Accumulate Unit

This block is one stage of a vector execution pipeline. It takes a source vector and an old destination vector. It splits both into lanes of 8, 16, 32 or 64 bits and shifts every source lane right by an immediate amount. Each lane can optionally be rounded to nearest and optionally added to the matching destination lane. The result is registered, so it appears one clock after the request.

The shift can be logical, filling with zeros, or arithmetic, filling with the sign. When rounding is on, half of the last discarded weight is added before the shift. The vector can be 64 or 128 bits wide; in the narrow form the upper half of the result reads as zero. In scalar mode only the lowest lane is computed and every other bit of the result is zero. Instruction decode and register-file access sit outside this block.

Top module: `lane_rshift_acc`

## Requirements
- R1: `sizeSel` picks the lane width W = 8 << sizeSel (0→8, 1→16, 2→32, 3→64 bits). Lane i of every vector occupies bits [i*W +: W], and the lanes are processed independently.
- R2: With `isSigned`=0, each lane is taken as an unsigned value and shifted right logically by `shiftAmt`, filling with zeros.
- R3: With `isSigned`=1, each lane is taken as two's complement and shifted right arithmetically, filling with copies of its sign bit.
- R4: `shiftAmt` ranges from 1 to W. A shift equal to W yields 0 (unsigned) or all copies of the sign bit (signed) before rounding and accumulation.
- R5: With `doRound`=1, the value 1 << (shiftAmt−1) is added to the extended lane before shifting. No carry is lost, including for 64-bit lanes.
- R6: With `doAccum`=1, the shifted lane is added to the same lane of `dstVec`, and the sum wraps modulo 2^W.
- R7: With `isWide`=0 (64-bit vector), result bits 127:64 are zero.
- R8: With `isScalar`=1, only lane 0 is computed. All result bits above lane 0 are zero, whatever `isWide` is.
- R9: A request with `inValid`=1 at a rising edge makes `resVec` hold its result and `resValid` read 1 after that edge. `resValid` reads 0 after any edge where `inValid` was 0.
- R10: While `rstN` is low, `resVec` is zero and `resValid` is 0.
- R11: `resVec` keeps its value across edges where `inValid` is 0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe; the inputs are sampled when high |
| srcVec | input | 128 | Source vector whose lanes are shifted |
| dstVec | input | 128 | Old destination vector used for accumulation |
| sizeSel | input | 2 | Lane width select, W = 8 << sizeSel |
| shiftAmt | input | 7 | Right-shift amount, 1 to W |
| isSigned | input | 1 | 1 = arithmetic shift, 0 = logical shift |
| doRound | input | 1 | 1 = add 1 << (shiftAmt−1) before the shift |
| doAccum | input | 1 | 1 = add the shifted lane to the destination lane |
| isScalar | input | 1 | 1 = lane 0 only, all other bits zero |
| isWide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| resValid | output | 1 | Single-cycle pulse marking a new result |
| resVec | output | 128 | Registered result vector |

## Verification
The bench sweeps every shift amount from 1 to the full lane width, for every lane size and every combination of sign, rounding and accumulation. Each sweep runs with ordinary random data, with all-ones lanes and with lanes holding the most negative value. A unit that drops the rounding carry on 64-bit lanes would return a wrong top bit for all-ones data. One that handles a full-width shift as a shift of zero would return the source lane unchanged where zero or the sign fill is expected. One that carries accumulation across lane boundaries would corrupt the neighbouring lane. The narrow and scalar forms are checked for stray nonzero bits above the live lanes. Between requests the inputs are scrambled, and the result is checked to stay put.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;
  localparam int MAX_LANE  = MIN_LANE << (NUM_SIZES - 1);
  localparam int VEC_BITS  = 2 * MAX_LANE;
  localparam int NUM_BYTES = VEC_BITS / 8;
  localparam int SIZE_W    = $clog2(NUM_SIZES);
  localparam int SHIFT_W   = $clog2(MAX_LANE) + 1;

  typedef struct packed {
    logic                 load;
    logic                 isSigned;
    logic                 doRound;
    logic                 doAccum;
    logic [SIZE_W-1:0]    sizeSel;
    logic [SHIFT_W-1:0]   shiftAmt;
    logic [NUM_BYTES-1:0] byteKeep;
  } strobe_t;
endpackage

// File: rtl/rsa_lane.sv
module rsa_lane #(
  parameter int W       = 8,
  parameter int SHIFT_W = 7
) (
  input  logic [W-1:0]       laneSrc,
  input  logic [W-1:0]       laneDst,
  input  logic [SHIFT_W-1:0] shAmt,
  input  logic               sgn,
  input  logic               rnd,
  input  logic               acc,
  output logic [W-1:0]       laneRes
);
  // Two guard bits: one keeps the sign, one takes the rounding carry.
  localparam int EW = W + 2;

  logic signed [EW-1:0] extVal;
  logic signed [EW-1:0] rndConst;
  logic signed [EW-1:0] sumVal;
  logic signed [EW-1:0] shifted;
  logic [SHIFT_W-1:0]   rndPos;

  always_comb begin
    extVal   = sgn ? {{2{laneSrc[W-1]}}, laneSrc} : {2'b00, laneSrc};
    rndPos   = shAmt - SHIFT_W'(1);
    rndConst = (rnd && shAmt != '0) ? ({{(EW-1){1'b0}}, 1'b1} << rndPos) : '0;
    sumVal   = extVal + rndConst;
    // An unsigned lane has a zero top bit, so the arithmetic shift fills with zeros.
    shifted  = sumVal >>> shAmt;
    laneRes  = shifted[W-1:0] + (acc ? laneDst : '0);
  end
endmodule

// File: rtl/rsa_ctrl.sv
module rsa_ctrl
  import rsa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [SIZE_W-1:0]  sizeSel,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               isSigned,
  input  logic               doRound,
  input  logic               doAccum,
  input  logic               isScalar,
  input  logic               isWide,
  output strobe_t            strb,
  output logic               resValid
);
  localparam int HALF_BYTES = NUM_BYTES / 2;

  logic [NUM_BYTES-1:0] keepBits;

  always_comb begin
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (isScalar) keepBits[b] = (b < (1 << sizeSel));
      else          keepBits[b] = isWide || (b < HALF_BYTES);
    end
  end

  always_comb begin
    strb.load     = inValid;
    strb.isSigned = isSigned;
    strb.doRound  = doRound;
    strb.doAccum  = doAccum;
    strb.sizeSel  = sizeSel;
    strb.shiftAmt = shiftAmt;
    strb.byteKeep = keepBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rstN) inValid |=> resValid);  // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> !resValid); // R9
endmodule

// File: rtl/rsa_datapath.sv
module rsa_datapath
  import rsa_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [VEC_BITS-1:0] srcVec,
  input  logic [VEC_BITS-1:0] dstVec,
  output logic [VEC_BITS-1:0] resVec
);
  logic [VEC_BITS-1:0] bySize [NUM_SIZES];
  logic [VEC_BITS-1:0] bitKeep;
  logic [VEC_BITS-1:0] nextRes;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int W = MIN_LANE << s;
    localparam int N = VEC_BITS / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      rsa_lane #(.W(W), .SHIFT_W(SHIFT_W)) u_lane (
        .laneSrc (srcVec[i*W +: W]),
        .laneDst (dstVec[i*W +: W]),
        .shAmt   (strb.shiftAmt),
        .sgn     (strb.isSigned),
        .rnd     (strb.doRound),
        .acc     (strb.doAccum),
        .laneRes (bySize[s][i*W +: W])
      );
    end
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_keep
    assign bitKeep[b*8 +: 8] = {8{strb.byteKeep[b]}};
  end

  always_comb nextRes = bySize[strb.sizeSel] & bitKeep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          resVec <= '0;
    else if (strb.load) resVec <= nextRes;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN) !strb.load |=> $stable(resVec)); // R11
endmodule

// File: rtl/lane_rshift_acc.sv
module lane_rshift_acc
  import rsa_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [VEC_BITS-1:0] srcVec,
  input  logic [VEC_BITS-1:0] dstVec,
  input  logic [SIZE_W-1:0]   sizeSel,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  input  logic                isSigned,
  input  logic                doRound,
  input  logic                doAccum,
  input  logic                isScalar,
  input  logic                isWide,
  output logic                resValid,
  output logic [VEC_BITS-1:0] resVec
);
  strobe_t strb;

  rsa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sizeSel  (sizeSel),
    .shiftAmt (shiftAmt),
    .isSigned (isSigned),
    .doRound  (doRound),
    .doAccum  (doAccum),
    .isScalar (isScalar),
    .isWide   (isWide),
    .strb     (strb),
    .resValid (resValid)
  );

  rsa_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .srcVec (srcVec),
    .dstVec (dstVec),
    .resVec (resVec)
  );

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isWide) |=> (resVec[VEC_BITS-1:VEC_BITS/2] == '0)); // R7
  AST_SCALAR_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isScalar && sizeSel == '0) |=> (resVec[VEC_BITS-1:MIN_LANE] == '0)); // R8
  AST_FULL_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isWide && !isScalar && !isSigned && !doRound && !doAccum
     && sizeSel == '0 && shiftAmt == SHIFT_W'(MIN_LANE)) |=> (resVec == '0)); // R4
endmodule

// File: tb/lane_rshift_acc_test.sv
`timescale 1ns/1ps
module lane_rshift_acc_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [127:0] srcVec = '0;
  logic [127:0] dstVec = '0;
  logic [1:0]   sizeSel = '0;
  logic [6:0]   shiftAmt = 7'd1;
  logic         isSigned = 1'b0, doRound = 1'b0, doAccum = 1'b0;
  logic         isScalar = 1'b0, isWide = 1'b1;
  logic         resValid;
  logic [127:0] resVec;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_rshift_acc uut (.*);

  function automatic logic [63:0] refLane(logic [63:0] s, logic [63:0] d, int w, int sh,
                                          bit sg, bit rn, bit ac);
    logic signed [66:0] v;
    logic [63:0] m;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    v = $signed({3'b000, s & m});
    if (sg && s[w-1]) v = v - (67'sd1 <<< w);
    if (rn) v = v + (67'sd1 <<< (sh - 1));
    v = v >>> sh;
    return (v[63:0] + (ac ? (d & m) : 64'd0)) & m;
  endfunction

  function automatic string tagOf(int w, int sh, bit sg, bit rn, bit ac, bit sc, bit wd);
    if (sc) return "R8";
    if (!wd) return "R7";
    if (sh == w) return "R4";
    if (rn) return "R5";
    if (ac) return "R6";
    if (sg) return "R3";
    return "R1/R2";
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(logic [127:0] s, logic [127:0] d, int sz, int sh,
                       bit sg, bit rn, bit ac, bit sc, bit wd);
    logic [127:0] exp;
    int w;
    int n;
    w = 8 << sz;
    n = 128 / w;
    exp = '0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] ls, ld, lr;
      ls = 64'(s >> (i * w));
      ld = 64'(d >> (i * w));
      lr = refLane(ls, ld, w, sh, sg, rn, ac);
      if (!(sc && i != 0)) exp = exp | (128'(lr) << (i * w));
    end
    if (!wd || sc) exp[127:64] = '0;
    @(negedge clk);
    srcVec = s; dstVec = d; sizeSel = 2'(sz); shiftAmt = 7'(sh);
    isSigned = sg; doRound = rn; doAccum = ac; isScalar = sc; isWide = wd;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tagOf(w, sh, sg, rn, ac, sc, wd), resVec, exp);
    check("R9 valid", {127'd0, resValid}, 128'd1);
    srcVec = ~s; dstVec = ~d; shiftAmt = 7'd1; doAccum = ~ac; isWide = ~wd;
    @(negedge clk);
    check("R11 hold", resVec, exp);
    check("R9 pulse", {127'd0, resValid}, 128'd0);
  endtask

  function automatic logic [127:0] minPattern(int sz);
    logic [127:0] p;
    int w;
    w = 8 << sz;
    p = '0;
    for (int i = 0; i < 128 / w; i++) p[i*w + w - 1] = 1'b1;
    return p;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset data", resVec, '0);
    check("R10 reset valid", {127'd0, resValid}, '0);
    rstN = 1'b1;
    // Lane placement: 16-bit lanes, unsigned shift by 4
    runOp({8{16'h1230}}, '0, 1, 4, 0, 0, 0, 0, 1);
    check("R1 lane placement", resVec, {8{16'h0123}});
    // Rounding carry at 64-bit lanes must not be lost
    runOp('1, '0, 3, 64, 0, 1, 0, 0, 1);
    check("R5 64-bit carry", resVec, {2{64'd1}});
    // Accumulation wraps within each byte lane
    runOp({16{8'hFF}}, {16{8'h01}}, 0, 8, 1, 0, 1, 0, 1);
    check("R6 wrap", resVec, '0);
    for (int sz = 0; sz < 4; sz++) begin
      for (int sh = 1; sh <= (8 << sz); sh++) begin
        for (int f = 0; f < 8; f++) begin
          for (int p = 0; p < 3; p++) begin
            logic [127:0] s, d;
            d = {$urandom, $urandom, $urandom, $urandom};
            s = (p == 0) ? {$urandom, $urandom, $urandom, $urandom}
              : (p == 1) ? '1 : minPattern(sz);
            runOp(s, d, sz, sh, f[0], f[1], f[2], 0, 1);
            if (p == 0) begin
              runOp(s, d, sz, sh, f[0], f[1], f[2], 0, 0);
              runOp(s, d, sz, sh, f[0], f[1], f[2], 1, (sh % 2) == 1);
            end
          end
        end
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule